// File: doc/BRIEF.md
# Dual-Polynomial Signature Compactor

This block folds a parallel word of circuit-under-test responses into a single modular linear feedback shift register, one word per enabled clock. Each stage takes the bit below it (stage 0 takes the top bit), adds the feedback tap when the top bit is set, and XORs in its own data bit. Because the register is linear, the final value equals the XOR of the remainders that each response bit stream would leave on its own. With independent errors, a k-bit register aliases with probability about 2^-k from any starting state.

The same response stream is meant to be compacted twice, once with each of two feedback polynomials. A 2:1 select picks the polynomial. The select is captured when an epoch starts, so the polynomial stays fixed for that epoch. A clear both ends the running epoch and zeroes the register for the next one. When it ends an epoch, the final signature is compared against the golden value that belongs to that epoch's polynomial. The overall pass flag rises only once both polynomials have a recorded match, so a fault that aliases under one polynomial is still caught by the other.

Top module: `dual_poly_misr`

## Requirements
- R1: On a cycle with `en_i` high and `clr_i` low, the next signature is: the current signature shifted up one bit with 0 entering bit 0; then XOR the tap vector if the current bit W-1 was 1; then XOR `data_i`. The tap vector is `POLY_A` (select 0) or `POLY_B` (select 1), with bit 0 always forced to 1.
- R2: A cycle with `clr_i` high makes the signature all zeros on the next cycle. This overrides `en_i`, and `data_i` has no effect on that cycle.
- R3: A cycle with both `clr_i` and `en_i` low leaves the signature unchanged.
- R4: After reset the signature is zero and `pass_o` is low.
- R5: The polynomial for an epoch is taken from `poly_sel_i` on the first enabled cycle after a clear or reset. Later changes of `poly_sel_i` have no effect until the next clear.
- R6: A clear that comes after at least one enabled cycle closes the epoch. It compares the signature against `golden_a_i` (epoch select 0) or `golden_b_i` (epoch select 1) and records the result for that polynomial. A clear with no enabled cycle since the last clear or reset records nothing. The golden inputs are used only at a closing clear.
- R7: `pass_o` is high exactly when both polynomials have a recorded verdict and both verdicts are matches. A later epoch with the same polynomial overwrites that polynomial's verdict, and `pass_o` follows one cycle after the closing clear.
- R8: Compaction is linear: from a zero start, under one polynomial, the signature of the stream d1 XOR d2 equals the XOR of the signatures of d1 and of d2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Ends the current epoch and zeroes the register |
| en_i | input | 1 | Compact `data_i` this cycle |
| data_i | input | W | Parallel response word, one bit per stage |
| poly_sel_i | input | 1 | Polynomial select: 0 for A, 1 for B |
| golden_a_i | input | W | Expected signature for a polynomial-A epoch |
| golden_b_i | input | W | Expected signature for a polynomial-B epoch |
| sig_o | output | W | Current signature |
| pass_o | output | 1 | Both epochs closed with matching signatures |

## Verification
A wrong tap, a wrong shift or a lost data bit changes `sig_o` on the very next enabled cycle. The bench therefore compares the signature on every cycle rather than only at the end of an epoch. A polynomial that is not held for the whole epoch shows up as a divergence on the first enabled cycle whose top bit is 1 after the select toggles. A fault in the verdict state shows on `pass_o` one cycle after a closing clear, or as a change of `pass_o` on a non-closing cycle.

// File: rtl/dual_poly_misr_pkg.sv
package dual_poly_misr_pkg;

    typedef enum logic {
        POLY_A = 1'b0,
        POLY_B = 1'b1
    } poly_id_e;

    localparam int unsigned NUM_POLY = 2;

endpackage

// File: rtl/dual_poly_misr_step.sv
module dual_poly_misr_step
    import dual_poly_misr_pkg::*;
#(
    parameter int unsigned W      = 16,
    parameter logic [W-1:0] POLY_A_TAPS = 16'h1021,
    parameter logic [W-1:0] POLY_B_TAPS = 16'h8005
) (
    input  logic [W-1:0] state_i,
    input  logic [W-1:0] data_i,
    input  poly_id_e     sel_i,
    output logic [W-1:0] next_o
);

    // Stage 0 always receives the feedback bit.
    localparam logic [W-1:0] TAP_A = POLY_A_TAPS | {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TAP_B = POLY_B_TAPS | {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] taps;
    logic         fb;

    always_comb begin
        taps = (sel_i == POLY_B) ? TAP_B : TAP_A;
        fb   = state_i[W-1];
    end

    for (genvar g = 0; g < W; g++) begin : g_stage
        if (g == 0) begin : g_low
            assign next_o[g] = fb ^ data_i[g];
        end else begin : g_mid
            assign next_o[g] = state_i[g-1] ^ (fb & taps[g]) ^ data_i[g];
        end
    end

endmodule

// File: rtl/dual_poly_misr_reg.sv
module dual_poly_misr_reg
    import dual_poly_misr_pkg::*;
#(
    parameter int unsigned  W           = 16,
    parameter logic [W-1:0] POLY_A_TAPS = 16'h1021,
    parameter logic [W-1:0] POLY_B_TAPS = 16'h8005
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] data_i,
    input  poly_id_e     poly_sel_i,
    output logic [W-1:0] sig_o,
    output logic         active_o,
    output poly_id_e     epoch_sel_o
);

    typedef struct packed {
        logic [W-1:0] sig;
        logic         active;
        poly_id_e     sel;
    } reg_state_t;

    reg_state_t   state_d, state_q;
    poly_id_e     eff_sel;
    logic [W-1:0] stepped;

    // The polynomial is locked once the epoch has started.
    assign eff_sel = state_q.active ? state_q.sel : poly_sel_i;

    dual_poly_misr_step #(
        .W           (W),
        .POLY_A_TAPS (POLY_A_TAPS),
        .POLY_B_TAPS (POLY_B_TAPS)
    ) i_step (
        .state_i (state_q.sig),
        .data_i  (data_i),
        .sel_i   (eff_sel),
        .next_o  (stepped)
    );

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.sig    = '0;
            state_d.active = 1'b0;
        end else if (en_i) begin
            state_d.sig    = stepped;
            state_d.active = 1'b1;
            if (!state_q.active) begin
                state_d.sel = poly_sel_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{sig: '0, active: 1'b0, sel: POLY_A};
        end else begin
            state_q <= state_d;
        end
    end

    assign sig_o       = state_q.sig;
    assign active_o    = state_q.active;
    assign epoch_sel_o = state_q.sel;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sig_o == '0)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(sig_o)); // R3
    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !clr_i) |=> $stable(epoch_sel_o)); // R5
    AST_EPOCH_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && en_i) |=> active_o); // R6

endmodule

// File: rtl/dual_poly_misr_judge.sv
module dual_poly_misr_judge
    import dual_poly_misr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         active_i,
    input  poly_id_e     epoch_sel_i,
    input  logic [W-1:0] sig_i,
    input  logic [W-1:0] golden_a_i,
    input  logic [W-1:0] golden_b_i,
    output logic         pass_o
);

    typedef struct packed {
        logic [NUM_POLY-1:0] seen;
        logic [NUM_POLY-1:0] ok;
    } verdict_t;

    verdict_t            verdict_d, verdict_q;
    logic                close_epoch;
    logic [NUM_POLY-1:0] slot_hit;
    logic [NUM_POLY-1:0] slot_match;

    assign close_epoch = clr_i & active_i;

    for (genvar p = 0; p < NUM_POLY; p++) begin : g_slot
        logic [W-1:0] golden;
        if (p == 0) begin : g_a
            assign golden = golden_a_i;
        end else begin : g_b
            assign golden = golden_b_i;
        end
        assign slot_hit[p]   = close_epoch && (int'(epoch_sel_i) == p);
        assign slot_match[p] = (sig_i == golden);
    end

    always_comb begin
        verdict_d = verdict_q;
        for (int p = 0; p < NUM_POLY; p++) begin
            if (slot_hit[p]) begin
                verdict_d.seen[p] = 1'b1;
                verdict_d.ok[p]   = slot_match[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign pass_o = (&verdict_q.seen) & (&verdict_q.ok);

    AST_VERDICT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_i && active_i) |=> $stable(verdict_q)); // R6
    AST_PASS_RISES_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_i && active_i) |=> !$rose(pass_o)); // R7
    AST_ONE_SLOT_PER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit)); // R6

endmodule

// File: rtl/dual_poly_misr.sv
module dual_poly_misr
    import dual_poly_misr_pkg::*;
#(
    parameter int unsigned  W           = 16,
    parameter logic [W-1:0] POLY_A_TAPS = 16'h1021,
    parameter logic [W-1:0] POLY_B_TAPS = 16'h8005
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] data_i,
    input  logic         poly_sel_i,
    input  logic [W-1:0] golden_a_i,
    input  logic [W-1:0] golden_b_i,
    output logic [W-1:0] sig_o,
    output logic         pass_o
);

    logic     active;
    poly_id_e epoch_sel;

    dual_poly_misr_reg #(
        .W           (W),
        .POLY_A_TAPS (POLY_A_TAPS),
        .POLY_B_TAPS (POLY_B_TAPS)
    ) i_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .en_i        (en_i),
        .data_i      (data_i),
        .poly_sel_i  (poly_id_e'(poly_sel_i)),
        .sig_o       (sig_o),
        .active_o    (active),
        .epoch_sel_o (epoch_sel)
    );

    dual_poly_misr_judge #(
        .W (W)
    ) i_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .active_i    (active),
        .epoch_sel_i (epoch_sel),
        .sig_i       (sig_o),
        .golden_a_i  (golden_a_i),
        .golden_b_i  (golden_b_i),
        .pass_o      (pass_o)
    );

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sig_o == '0 && !pass_o)); // R4

endmodule

// File: tb/test_dual_poly_misr.sv
module test_dual_poly_misr;

    localparam int unsigned W  = 16;
    localparam logic [W-1:0] PA = 16'h1021;
    localparam logic [W-1:0] PB = 16'h8005;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] data = '0;
    logic         sel = 1'b0;
    logic [W-1:0] gold_a = '0;
    logic [W-1:0] gold_b = '0;
    logic [W-1:0] sig;
    logic         pass;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [W-1:0] m_sig = '0;
    logic         m_act = 1'b0;
    logic         m_sel = 1'b0;
    logic [1:0]   m_seen = '0;
    logic [1:0]   m_ok = '0;

    always #2 clk = ~clk;

    dual_poly_misr #(.W(W), .POLY_A_TAPS(PA), .POLY_B_TAPS(PB)) i_dual_poly_misr (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en), .data_i(data),
        .poly_sel_i(sel), .golden_a_i(gold_a), .golden_b_i(gold_b),
        .sig_o(sig), .pass_o(pass)
    );

    function automatic logic [W-1:0] mstep(input logic [W-1:0] s, input logic [W-1:0] d,
                                           input logic ps);
        logic [W-1:0] t;
        t = {s[W-2:0], 1'b0};
        if (s[W-1]) t = t ^ ((ps ? PB : PA) | 1);
        return t ^ d;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, check at the next negedge.
    task automatic run(input logic c, input logic e, input logic [W-1:0] d, input logic s,
                       input string req);
        clr = c; en = e; data = d; sel = s;
        if (c) begin
            if (m_act) begin
                m_seen[m_sel] = 1'b1;
                m_ok[m_sel]   = (m_sig == (m_sel ? gold_b : gold_a));
            end
            m_sig = '0;
            m_act = 1'b0;
        end else if (e) begin
            if (!m_act) m_sel = s;
            m_act = 1'b1;
            m_sig = mstep(m_sig, d, m_sel);
        end
        @(negedge clk);
        chk(req, sig, m_sig);
        chk(req, {{(W-1){1'b0}}, pass}, {{(W-1){1'b0}}, (&m_seen) & (&m_ok)});
    endtask

    task automatic epoch(input logic s, input int n, input string req);
        run(1'b0, 1'b1, W'($urandom), s, req);
        for (int i = 1; i < n; i++) begin
            run(1'b0, ($urandom % 4) != 0, W'($urandom), 1'(($urandom)), req);
        end
    endtask

    logic [W-1:0] s1, s2, s3;
    logic [W-1:0] d1 [20];
    logic [W-1:0] d2 [20];
    bit done = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R4", sig, '0);
        chk("R4", {{(W-1){1'b0}}, pass}, '0);

        // Hand-checked first step under A: 0x8000 then data 0 -> 0x1021
        run(1'b0, 1'b1, 16'h8000, 1'b0, "R1");
        run(1'b0, 1'b1, 16'h0000, 1'b0, "R1");
        chk("R1", sig, 16'h1021);
        run(1'b0, 1'b0, 16'hFFFF, 1'b1, "R3");

        // Epoch A with select toggling mid-epoch
        run(1'b1, 1'b0, '0, 1'b0, "R2");
        epoch(1'b0, 40, "R1 R3 R5");
        gold_a = m_sig; gold_b = W'($urandom);
        run(1'b1, 1'b0, '0, 1'b0, "R2 R6");

        // Epoch B, correct golden -> pass
        epoch(1'b1, 50, "R1 R3 R5");
        gold_b = m_sig;
        run(1'b1, 1'b0, '0, 1'b1, "R6 R7");
        chk("R7", {{(W-1){1'b0}}, pass}, 16'h0001);

        // Clear with enable high and no epoch open: zero, verdicts untouched
        run(1'b1, 1'b1, 16'hBEEF, 1'b0, "R2 R6");
        gold_a = ~gold_a; gold_b = ~gold_b;
        run(1'b0, 1'b0, '0, 1'b0, "R6");
        run(1'b1, 1'b0, '0, 1'b0, "R6");

        // Re-run A with wrong golden, then with the correct one
        epoch(1'b0, 30, "R1 R5");
        gold_a = m_sig ^ 16'h0001;
        run(1'b1, 1'b0, '0, 1'b0, "R7");
        chk("R7", {{(W-1){1'b0}}, pass}, '0);
        gold_b = ~m_sig;
        epoch(1'b0, 30, "R1 R5");
        gold_a = m_sig;
        run(1'b1, 1'b0, '0, 1'b0, "R7");
        epoch(1'b1, 25, "R1 R5");
        gold_b = m_sig;
        run(1'b1, 1'b0, '0, 1'b0, "R7");
        chk("R7", {{(W-1){1'b0}}, pass}, 16'h0001);

        // Linearity under polynomial B
        for (int i = 0; i < 20; i++) begin
            d1[i] = W'($urandom); d2[i] = W'($urandom);
        end
        for (int i = 0; i < 20; i++) run(1'b0, 1'b1, d1[i], 1'b1, "R8");
        s1 = sig;
        run(1'b1, 1'b0, '0, 1'b1, "R8");
        for (int i = 0; i < 20; i++) run(1'b0, 1'b1, d2[i], 1'b1, "R8");
        s2 = sig;
        run(1'b1, 1'b0, '0, 1'b1, "R8");
        for (int i = 0; i < 20; i++) run(1'b0, 1'b1, d1[i] ^ d2[i], 1'b1, "R8");
        s3 = sig;
        chk("R8", s3, s1 ^ s2);

        // Reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_sig = '0; m_act = 1'b0; m_seen = '0; m_ok = '0;
        chk("R4", sig, '0);
        chk("R4", {{(W-1){1'b0}}, pass}, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule